// File: doc/BRIEF.md
# Boundary Test Pattern Engine

This block is the test-pattern side of a scan-testable octal transceiver. An 11-bit control word sits in the scan path when the test access port selects it. The word has a serial shift stage and a shadow stage. The shadow copy picks one of several self-test operations and holds a per-bit input mask. The engine works on one 8-bit input sample and one 8-bit output drive value:

- it compresses the sampled inputs into a signature,
- it generates pseudo-random words on the outputs,
- it toggles the outputs while it samples the inputs, or
- it counts on the outputs.

The chosen operation moves forward one step per test clock, and only while the TAP controller is in Run-Test/Idle. At all other times it holds its state. The TAP controller sequencing lives outside this block and supplies qualified capture, shift and update strobes. The test data output is valid whenever the chain is shifting. The result registers are read back by capturing them into the chain and shifting them out, least significant bit first.

The shadow operation code is mirrored in a mode state register with these states: `ST_SIG`, `ST_SIGM`, `ST_PRPG`, `ST_TOG`, `ST_CNT` and `ST_HOLD`.

Mode transitions:

- Reset enters `ST_SIG`.
- Every update strobe moves the mode to the state that the newly shifted code decodes to: 010 to `ST_SIG`, 011 to `ST_SIGM`, 100 to `ST_PRPG`, 101 to `ST_TOG`, 110 to `ST_CNT`, and any other code to `ST_HOLD`.
- Without an update strobe the state stays where it is.

Top module: `scan_pattern_engine`

## Requirements
- R1: After reset the shadow control word is 00000000010 (code 010, mask 0), the mode is `ST_SIG`, and both the output value and the signature register are 0.
- R2: With `shift_en` high, the chain moves one place toward `tdo` per rising `tck`, taking `tdi` into bit 10, and `tdo` shows bit 0. The shadow word, and so the operation, changes only on a rising edge with `update_en` high.
- R3: A rising edge with `capture_en` high loads the chain as follows. Bits 2..0 get the current operation code. Bits 10..3 get one of three values: the signature/sample register for codes 010, 011 and 101; the output value for codes 100 and 110; the shadow mask for any other code.
- R4: While `run_idle` is low, neither the output value nor the signature register changes, whatever `in_sample` does.
- R5: Under code 010, each step sets sig = L(sig) XOR in_sample. Here L(v) shifts v left by one and XORs 8'h1D into the result when the old bit 7 was 1, which is the polynomial x^8+x^4+x^3+x^2+1.
- R6: Under code 011, input bits whose mask bit (control bit 3+i for input i) is 1 are left out of the XOR. Under code 010 the mask has no effect.
- R7: Under code 100, each step sets out = L(out). An output value of 0 is replaced by 00000001 instead.
- R8: Under code 110, each step adds one to the output value, and 255 wraps to 0.
- R9: Under code 101, each step inverts the output value and loads the signature/sample register with `in_sample`.
- R10: Under any code other than 010 to 110, steps change neither the output value nor the signature register.
- R11: `out_drive` always equals the output value register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low test logic reset |
| capture_en | input | 1 | Capture strobe, qualified for this register |
| shift_en | input | 1 | Shift strobe, qualified for this register |
| update_en | input | 1 | Update strobe, qualified for this register |
| run_idle | input | 1 | High while the TAP controller is in Run-Test/Idle |
| tdi | input | 1 | Serial data into the control chain |
| tdo | output | 1 | Serial data out, bit 0 of the chain |
| in_sample | input | 8 | Sampled input-side values |
| out_drive | output | 8 | Output-side drive value |

## Verification
The bench builds the block with its default parameters: an 8-bit data width, a 3-bit code, and the tap mask 8'h1D. With these defaults the count pattern can be run all the way through its wrap from 255 to 0 in a few hundred clocks. They also put the zero-seed case of the pseudo-random mode within reach straight after reset. Every readback shifts out the full 11-bit chain, so the code field and the data field are both checked in one scan.

// File: rtl/scan_pat_pkg.sv
package scan_pat_pkg;

    typedef enum logic [2:0] {
        ST_HOLD = 3'b000,
        ST_SIG  = 3'b001,
        ST_SIGM = 3'b010,
        ST_PRPG = 3'b011,
        ST_TOG  = 3'b100,
        ST_CNT  = 3'b101
    } mode_e;

    localparam logic [2:0] CODE_SIG  = 3'b010;
    localparam logic [2:0] CODE_SIGM = 3'b011;
    localparam logic [2:0] CODE_PRPG = 3'b100;
    localparam logic [2:0] CODE_TOG  = 3'b101;
    localparam logic [2:0] CODE_CNT  = 3'b110;

    function automatic mode_e decode_code(input logic [2:0] code);
        mode_e m;
        case (code)
            CODE_SIG:  m = ST_SIG;
            CODE_SIGM: m = ST_SIGM;
            CODE_PRPG: m = ST_PRPG;
            CODE_TOG:  m = ST_TOG;
            CODE_CNT:  m = ST_CNT;
            default:   m = ST_HOLD;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/lfsr_next.sv
module lfsr_next #(
    parameter int unsigned    W    = 8,
    parameter logic [W-1:0]   TAPS = 8'h1D
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);
    logic fb;
    assign fb = cur[W-1];

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign nxt[i] = fb & TAPS[i];
        end else begin : g_up
            assign nxt[i] = cur[i-1] ^ (fb & TAPS[i]);
        end
    end
endmodule

// File: rtl/ctl_chain.sv
module ctl_chain #(
    parameter int unsigned      CTL_W = 11,
    parameter logic [CTL_W-1:0] RST_WORD = 11'b00000000010
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             capture_en,
    input  logic             shift_en,
    input  logic             update_en,
    input  logic             tdi,
    input  logic [CTL_W-1:0] cap_word,
    output logic             tdo,
    output logic [CTL_W-1:0] shadow_q
);
    logic [CTL_W-1:0] chain_q;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= RST_WORD;
        end else if (capture_en) begin
            chain_q <= cap_word;
        end else if (shift_en) begin
            chain_q <= {tdi, chain_q[CTL_W-1:1]};
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= RST_WORD;
        end else if (update_en) begin
            shadow_q <= chain_q;
        end
    end

    assign tdo = chain_q[0];

    AST_SHADOW_HELD: assert property (@(posedge tck) disable iff (!rst_n)
        !update_en |=> $stable(shadow_q)); // R2
    AST_SHIFT_MOVE: assert property (@(posedge tck) disable iff (!rst_n)
        (shift_en && !capture_en) |=> (chain_q[CTL_W-2:0] == $past(chain_q[CTL_W-1:1]))); // R2
endmodule

// File: rtl/engine_ctl.sv
module engine_ctl
    import scan_pat_pkg::*;
#(
    parameter int unsigned CODE_W = 3
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              update_en,
    input  logic              run_idle,
    input  logic [CODE_W-1:0] new_code,
    output mode_e             mode_q,
    output logic              step_misr,
    output logic              use_mask,
    output logic              step_sample,
    output logic              step_prpg,
    output logic              step_tog,
    output logic              step_cnt
);
    mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        if (update_en) begin
            mode_d = decode_code(new_code);
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= ST_SIG;
        end else begin
            mode_q <= mode_d;
        end
    end

    always_comb begin
        step_misr   = 1'b0;
        use_mask    = 1'b0;
        step_sample = 1'b0;
        step_prpg   = 1'b0;
        step_tog    = 1'b0;
        step_cnt    = 1'b0;
        unique case (mode_q)
            ST_SIG:  step_misr = run_idle;
            ST_SIGM: begin
                step_misr = run_idle;
                use_mask  = 1'b1;
            end
            ST_PRPG: step_prpg = run_idle;
            ST_TOG: begin
                step_tog    = run_idle;
                step_sample = run_idle;
            end
            ST_CNT:  step_cnt = run_idle;
            ST_HOLD: ;
            default: ;
        endcase
    end

    AST_MODE_HELD: assert property (@(posedge tck) disable iff (!rst_n)
        !update_en |=> $stable(mode_q)); // R2
    AST_ONE_STEP: assert property (@(posedge tck) disable iff (!rst_n)
        $onehot0({step_misr, step_prpg, step_tog, step_cnt})); // R10
endmodule

// File: rtl/sig_unit.sv
module sig_unit #(
    parameter int unsigned  DATA_W = 8,
    parameter logic [DATA_W-1:0] TAPS = 8'h1D
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              step_misr,
    input  logic              use_mask,
    input  logic              step_sample,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] in_sample,
    output logic [DATA_W-1:0] sig_q
);
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] in_eff;

    lfsr_next #(.W(DATA_W), .TAPS(TAPS)) u_step (
        .cur (sig_q),
        .nxt (shifted)
    );

    assign in_eff = use_mask ? (in_sample & ~mask) : in_sample;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            sig_q <= '0;
        end else if (step_misr) begin
            sig_q <= shifted ^ in_eff;
        end else if (step_sample) begin
            sig_q <= in_sample;
        end
    end

    AST_SIG_IDLE: assert property (@(posedge tck) disable iff (!rst_n)
        !(step_misr || step_sample) |=> $stable(sig_q)); // R4
    AST_SAMPLE_LOAD: assert property (@(posedge tck) disable iff (!rst_n)
        (step_sample && !step_misr) |=> (sig_q == $past(in_sample))); // R9
endmodule

// File: rtl/out_gen.sv
module out_gen #(
    parameter int unsigned  DATA_W = 8,
    parameter logic [DATA_W-1:0] TAPS = 8'h1D
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              step_prpg,
    input  logic              step_tog,
    input  logic              step_cnt,
    output logic [DATA_W-1:0] out_q
);
    localparam logic [DATA_W-1:0] SEED = {{(DATA_W-1){1'b0}}, 1'b1};
    logic [DATA_W-1:0] prpg_nxt;

    lfsr_next #(.W(DATA_W), .TAPS(TAPS)) u_step (
        .cur (out_q),
        .nxt (prpg_nxt)
    );

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (step_prpg) begin
            out_q <= (out_q == '0) ? SEED : prpg_nxt;
        end else if (step_tog) begin
            out_q <= ~out_q;
        end else if (step_cnt) begin
            out_q <= out_q + 1'b1;
        end
    end

    AST_OUT_IDLE: assert property (@(posedge tck) disable iff (!rst_n)
        !(step_prpg || step_tog || step_cnt) |=> $stable(out_q)); // R4
    AST_PRPG_NONZERO: assert property (@(posedge tck) disable iff (!rst_n)
        step_prpg |=> (out_q != '0)); // R7
    AST_TOGGLE_INV: assert property (@(posedge tck) disable iff (!rst_n)
        (step_tog && !step_prpg) |=> (out_q == ~$past(out_q))); // R9
    AST_COUNT_UP: assert property (@(posedge tck) disable iff (!rst_n)
        (step_cnt && !step_prpg && !step_tog) |=> (out_q == $past(out_q) + 1'b1)); // R8
endmodule

// File: rtl/scan_pattern_engine.sv
module scan_pattern_engine
    import scan_pat_pkg::*;
#(
    parameter int unsigned       DATA_W = 8,
    parameter int unsigned       CODE_W = 3,
    parameter logic [DATA_W-1:0] TAPS   = 8'h1D
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              capture_en,
    input  logic              shift_en,
    input  logic              update_en,
    input  logic              run_idle,
    input  logic              tdi,
    output logic              tdo,
    input  logic [DATA_W-1:0] in_sample,
    output logic [DATA_W-1:0] out_drive
);
    localparam int unsigned CTL_W = DATA_W + CODE_W;
    localparam logic [CTL_W-1:0] RST_WORD = CTL_W'(CODE_SIG);

    logic [CTL_W-1:0]  shadow;
    logic [CTL_W-1:0]  cap_word;
    logic [CODE_W-1:0] cur_code;
    logic [DATA_W-1:0] cur_mask;
    logic [DATA_W-1:0] sig_val;
    logic [DATA_W-1:0] out_val;
    logic [DATA_W-1:0] cap_data;
    mode_e             mode;
    logic step_misr, use_mask, step_sample, step_prpg, step_tog, step_cnt;
    logic [CTL_W-1:0]  chain_probe;

    assign cur_code = shadow[CODE_W-1:0];
    assign cur_mask = shadow[CTL_W-1:CODE_W];

    always_comb begin
        unique case (mode)
            ST_SIG, ST_SIGM, ST_TOG: cap_data = sig_val;
            ST_PRPG, ST_CNT:         cap_data = out_val;
            default:                 cap_data = cur_mask;
        endcase
    end
    assign cap_word = {cap_data, cur_code};

    ctl_chain #(.CTL_W(CTL_W), .RST_WORD(RST_WORD)) u_chain (
        .tck        (tck),
        .rst_n      (rst_n),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .update_en  (update_en),
        .tdi        (tdi),
        .cap_word   (cap_word),
        .tdo        (tdo),
        .shadow_q   (shadow)
    );

    assign chain_probe = u_chain.chain_q;

    engine_ctl #(.CODE_W(CODE_W)) u_ctl (
        .tck         (tck),
        .rst_n       (rst_n),
        .update_en   (update_en),
        .run_idle    (run_idle),
        .new_code    (chain_probe[CODE_W-1:0]),
        .mode_q      (mode),
        .step_misr   (step_misr),
        .use_mask    (use_mask),
        .step_sample (step_sample),
        .step_prpg   (step_prpg),
        .step_tog    (step_tog),
        .step_cnt    (step_cnt)
    );

    sig_unit #(.DATA_W(DATA_W), .TAPS(TAPS)) u_sig (
        .tck         (tck),
        .rst_n       (rst_n),
        .step_misr   (step_misr),
        .use_mask    (use_mask),
        .step_sample (step_sample),
        .mask        (cur_mask),
        .in_sample   (in_sample),
        .sig_q       (sig_val)
    );

    out_gen #(.DATA_W(DATA_W), .TAPS(TAPS)) u_out (
        .tck       (tck),
        .rst_n     (rst_n),
        .step_prpg (step_prpg),
        .step_tog  (step_tog),
        .step_cnt  (step_cnt),
        .out_q     (out_val)
    );

    assign out_drive = out_val;

    AST_MODE_MATCHES_CODE: assert property (@(posedge tck) disable iff (!rst_n)
        mode == decode_code(cur_code)); // R2
    AST_CAPTURE_CODE: assert property (@(posedge tck) disable iff (!rst_n)
        (capture_en && !update_en) |=> (tdo == $past(cur_code[0]))); // R3
    AST_QUIET_OUT: assert property (@(posedge tck) disable iff (!rst_n)
        !run_idle |=> $stable(out_drive)); // R4
endmodule

// File: tb/tb_scan_pattern_engine.sv
module tb_scan_pattern_engine;
    logic       tck = 1'b0;
    logic       rst_n = 1'b0;
    logic       capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0, run_idle = 1'b0;
    logic       tdi = 1'b0;
    logic       tdo;
    logic [7:0] in_sample = 8'h00;
    logic [7:0] out_drive;

    int checks = 0;
    int errors = 0;
    logic [7:0]  m_out = 8'h00;
    logic [7:0]  m_sig = 8'h00;
    logic [2:0]  m_code = 3'b010;
    logic [7:0]  m_mask = 8'h00;
    logic        saw_wrap = 1'b0;

    always #10 tck = ~tck;

    scan_pattern_engine dut (
        .tck(tck), .rst_n(rst_n), .capture_en(capture_en), .shift_en(shift_en),
        .update_en(update_en), .run_idle(run_idle), .tdi(tdi), .tdo(tdo),
        .in_sample(in_sample), .out_drive(out_drive)
    );

    function automatic logic [7:0] poly_step(input logic [7:0] v);
        return {v[6:0], 1'b0} ^ (v[7] ? 8'h1D : 8'h00);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_ctl(input logic [2:0] code, input logic [7:0] mask, input bit do_update);
        logic [10:0] w;
        w = {mask, code};
        for (int i = 0; i < 11; i++) begin
            shift_en = 1'b1;
            tdi = w[i];
            @(negedge tck);
        end
        shift_en = 1'b0;
        if (do_update) begin
            update_en = 1'b1;
            @(negedge tck);
            update_en = 1'b0;
            m_code = code;
            m_mask = mask;
        end
    endtask

    task automatic read_ctl(output logic [10:0] r);
        capture_en = 1'b1;
        @(negedge tck);
        capture_en = 1'b0;
        shift_en = 1'b1;
        tdi = 1'b0;
        for (int i = 0; i < 11; i++) begin
            r[i] = tdo;
            @(negedge tck);
        end
        shift_en = 1'b0;
    endtask

    task automatic model_step(input logic [7:0] p);
        case (m_code)
            3'b010: m_sig = poly_step(m_sig) ^ p;
            3'b011: m_sig = poly_step(m_sig) ^ (p & ~m_mask);
            3'b100: m_out = (m_out == 8'h00) ? 8'h01 : poly_step(m_out);
            3'b101: begin m_out = ~m_out; m_sig = p; end
            3'b110: begin
                if (m_out == 8'hFF) saw_wrap = 1'b1;
                m_out = m_out + 8'h01;
            end
            default: ;
        endcase
    endtask

    task automatic run_steps(input int n, input int seed, input string req);
        for (int i = 0; i < n; i++) begin
            logic [7:0] p;
            p = 8'((i * 37 + seed * 11 + 5) ^ (i << 3));
            in_sample = p;
            run_idle = 1'b1;
            @(negedge tck);
            model_step(p);
            check(req, 32'(out_drive), 32'(m_out)); // R11
        end
        run_idle = 1'b0;
    endtask

    task automatic check_readback(input string req, input logic [7:0] data);
        logic [10:0] r;
        read_ctl(r);
        check(req, 32'(r), 32'({data, m_code}));
    endtask

    task automatic t_reset;
        check("R1 out_drive", 32'(out_drive), 32'h00);
        check_readback("R1 R3 reset word", 8'h00);
    endtask

    task automatic t_prpg_zero_seed;
        write_ctl(3'b100, 8'h00, 1'b1);
        run_steps(1, 1, "R7 zero seed");
        check("R7 seed value", 32'(out_drive), 32'h01);
        run_steps(30, 2, "R7 prpg");
        check_readback("R3 R7 capture out", m_out);
    endtask

    task automatic t_sig_plain;
        write_ctl(3'b010, 8'hF0, 1'b1);
        run_steps(20, 3, "R5 sig");
        check_readback("R5 R6 mask ignored", m_sig);
    endtask

    task automatic t_sig_masked;
        write_ctl(3'b011, 8'h5A, 1'b1);
        run_steps(20, 4, "R6 masked");
        check_readback("R6 masked sig", m_sig);
    endtask

    task automatic t_hold;
        logic [7:0] o;
        o = out_drive;
        run_idle = 1'b0;
        for (int i = 0; i < 6; i++) begin
            in_sample = 8'(i * 53 + 1);
            @(negedge tck);
        end
        check("R4 out held", 32'(out_drive), 32'(o));
        check_readback("R4 sig held", m_sig);
    endtask

    task automatic t_count;
        write_ctl(3'b110, 8'h00, 1'b1);
        saw_wrap = 1'b0;
        run_steps(260, 5, "R8 count");
        check("R8 wrap seen", 32'(saw_wrap), 32'h1);
        check_readback("R3 R8 capture out", m_out);
    endtask

    task automatic t_toggle;
        write_ctl(3'b101, 8'h00, 1'b1);
        run_steps(7, 6, "R9 toggle");
        check_readback("R9 sample", m_sig);
    endtask

    task automatic t_nop;
        logic [7:0] o;
        write_ctl(3'b111, 8'hAA, 1'b1);
        o = out_drive;
        run_steps(10, 7, "R10 nop");
        check("R10 out kept", 32'(out_drive), 32'(o));
        check_readback("R10 R3 mask word", 8'hAA);
        write_ctl(3'b000, 8'h3C, 1'b1);
        run_steps(5, 8, "R10 nop0");
        check_readback("R10 R3 code 000", 8'h3C);
    endtask

    task automatic t_shift_no_update;
        logic [7:0] o;
        o = out_drive;
        write_ctl(3'b110, 8'h00, 1'b0);
        run_steps(4, 9, "R2 no update");
        check("R2 op unchanged", 32'(out_drive), 32'(o));
    endtask

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge tck);
        rst_n = 1'b1;
        @(negedge tck);
        t_reset();
        t_prpg_zero_seed();
        t_sig_plain();
        t_sig_masked();
        t_hold();
        t_count();
        t_toggle();
        t_nop();
        t_shift_no_update();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule